// File: doc/BRIEF.md
# 8-bit ALU with Status Flags

This block is the arithmetic and logic stage of a small 8-bit microcontroller datapath. Each cycle it takes two byte operands and a 5-bit operation code and produces a byte result at once, without any register in the path. It also produces the status byte that the operation would leave behind. When `op_valid` is high, the status byte is committed to an internal flag register at the next rising clock edge. The carry an operation consumes is the C bit already held in that register.

Each operation has its own mask of flags it may change. All other flags keep their old values. Unary operations use `op_a` only. Software can load the flag register directly through `flag_we`/`flag_wdata`.

There is no back-pressure. The block accepts an operation in every cycle in which `op_valid` is high, and `result` and `flags_next` follow the inputs combinationally.

Top module: `status_alu`

## Requirements
- R1: The status byte holds, from bit 7 down to bit 0: interrupt enable I, bit store T, half carry H, sign S, overflow V, negative N, zero Z, carry C. A synchronous `rst` clears the flag register to 0x00.
- R2: With `flag_we` high, the flag register takes `flag_wdata` at the next edge. This load wins over an operation presented in the same cycle.
- R3: ADD (code 0) and ADC (code 1) give a+b, and ADC also adds the stored C. C is the carry out of bit 7, H is the carry out of bit 3, V is signed overflow, and Z, N and S are updated.
- R4: SUB (code 2) and SBC (code 3) give a−b, and SBC also subtracts the stored C. C is the borrow out of bit 7, H is the borrow into bit 4, and V, N, Z and S are updated.
- R5: AND (4), OR (5) and XOR (6) update Z and N, clear V and recompute S. C and H keep their values.
- R6: COM (7) gives 0xFF−a, sets C, clears V, and updates Z, N and S while keeping H. NEG (8) gives 0x00−a and updates H, S, V, N, Z and C as a subtraction from zero.
- R7: INC (9) and DEC (10) give a+1 and a−1. They update Z, N, V and S and keep C and H. V is set for INC of 0x7F and for DEC of 0x80.
- R8: LSL (11) and LSR (12) fill the vacated bit with 0. C takes the bit shifted out, V = N xor C, and H is kept.
- R9: ROL (13) moves the stored C into bit 0 and bit 7 into C. ROR (14) moves the stored C into bit 7 and bit 0 into C. Both set V = N xor C.
- R10: ASR (15) keeps bit 7 and shifts bits 7..1 into 6..0. C takes old bit 0 and V = N xor C.
- R11: SWAP (16) exchanges the two nibbles of a and changes no flag.
- R12: Whenever N or V is written, S equals N xor V. No operation changes I or T.
- R13: With `op_valid` low and no load, the flags hold. Codes 17 to 31 pass a through to `result` and change no flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| op_valid | input | 1 | Commit this cycle's flags at the next edge |
| op_code | input | 5 | Operation code |
| op_a | input | 8 | First operand (sole operand of unary ops) |
| op_b | input | 8 | Second operand |
| flag_we | input | 1 | Direct load of the flag register |
| flag_wdata | input | 8 | Value for the direct load |
| result | output | 8 | Combinational result |
| flags_next | output | 8 | Status byte this operation would commit |
| flags_q | output | 8 | Registered status byte |

## Verification
The bench goes after the carry-chain corners:
- 0x80+0x80, where a wrong overflow or zero rule misreports signed wrap.
- ADC and SBC with the stored carry set, where a design that ignores C is off by one.
- NEG of 0x80 and of 0x00, where the borrow and overflow corners invert.

It also preloads flags before each operation so that a design with an over-wide mask is caught: one that lets INC touch C, lets logic ops clear H, or lets SWAP write flags shows changed bits. Rotates are run with both carry values, and ASR with a negative operand, to catch a fill taken from the wrong source. Direct directed cases probe the precedence of a load over an operation and reset over a loaded register.

// File: rtl/status_alu_pkg.sv
package status_alu_pkg;
  localparam int DW = 8;
  localparam int OPW = 5;

  localparam int FL_C = 0;
  localparam int FL_Z = 1;
  localparam int FL_N = 2;
  localparam int FL_V = 3;
  localparam int FL_S = 4;
  localparam int FL_H = 5;
  localparam int FL_T = 6;
  localparam int FL_I = 7;

  typedef enum logic [OPW-1:0] {
    OP_ADD  = 5'd0,  OP_ADC  = 5'd1,  OP_SUB  = 5'd2,  OP_SBC = 5'd3,
    OP_AND  = 5'd4,  OP_OR   = 5'd5,  OP_XOR  = 5'd6,  OP_COM = 5'd7,
    OP_NEG  = 5'd8,  OP_INC  = 5'd9,  OP_DEC  = 5'd10, OP_LSL = 5'd11,
    OP_LSR  = 5'd12, OP_ROL  = 5'd13, OP_ROR  = 5'd14, OP_ASR = 5'd15,
    OP_SWAP = 5'd16
  } alu_op_e;

  localparam logic [7:0] M_ARITH = 8'h3F;
  localparam logic [7:0] M_LOGIC = 8'h1E;
  localparam logic [7:0] M_SHIFT = 8'h1F;
  localparam logic [7:0] M_NONE  = 8'h00;
endpackage

// File: rtl/status_alu_addsub.sv
module status_alu_addsub #(
  parameter int W = 8
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic         cin,
  input  logic         sub,
  output logic [W-1:0] sum,
  output logic         c_out,
  output logic         h_out,
  output logic         v_out
);
  localparam int HW = W / 2;

  logic [W:0]  full;
  logic [HW:0] half;

  always_comb begin
    if (sub) begin
      full = {1'b0, a} - {1'b0, b} - {{W{1'b0}}, cin};
      half = {1'b0, a[HW-1:0]} - {1'b0, b[HW-1:0]} - {{HW{1'b0}}, cin};
    end else begin
      full = {1'b0, a} + {1'b0, b} + {{W{1'b0}}, cin};
      half = {1'b0, a[HW-1:0]} + {1'b0, b[HW-1:0]} + {{HW{1'b0}}, cin};
    end
    sum   = full[W-1:0];
    c_out = full[W];
    h_out = half[HW];
    if (sub)
      v_out = (a[W-1] & ~b[W-1] & ~sum[W-1]) | (~a[W-1] & b[W-1] & sum[W-1]);
    else
      v_out = (a[W-1] & b[W-1] & ~sum[W-1]) | (~a[W-1] & ~b[W-1] & sum[W-1]);
  end
endmodule

// File: rtl/status_alu_bitops.sv
module status_alu_bitops
  import status_alu_pkg::*;
#(
  parameter int W = 8
) (
  input  logic [OPW-1:0] op,
  input  logic [W-1:0]   a,
  input  logic [W-1:0]   b,
  input  logic           cin,
  output logic [W-1:0]   r,
  output logic           c_out
);
  localparam int HW = W / 2;

  always_comb begin
    r     = a;
    c_out = cin;
    case (op)
      OP_AND:  r = a & b;
      OP_OR:   r = a | b;
      OP_XOR:  r = a ^ b;
      OP_COM:  begin r = ~a;                      c_out = 1'b1;   end
      OP_LSL:  begin r = {a[W-2:0], 1'b0};        c_out = a[W-1]; end
      OP_LSR:  begin r = {1'b0, a[W-1:1]};        c_out = a[0];   end
      OP_ROL:  begin r = {a[W-2:0], cin};         c_out = a[W-1]; end
      OP_ROR:  begin r = {cin, a[W-1:1]};         c_out = a[0];   end
      OP_ASR:  begin r = {a[W-1], a[W-1:1]};      c_out = a[0];   end
      OP_SWAP: r = {a[HW-1:0], a[W-1:HW]};
      default: r = a;
    endcase
  end
endmodule

// File: rtl/status_alu_flagreg.sv
module status_alu_flagreg #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         we,
  input  logic [W-1:0] wdata,
  input  logic         upd,
  input  logic [W-1:0] upd_data,
  output logic [W-1:0] q
);
  always_ff @(posedge clk) begin
    if (rst)      q <= '0;
    else if (we)  q <= wdata;
    else if (upd) q <= upd_data;
  end

  assert_reset_clears_R1: assert property (@(posedge clk)
    rst |=> (q == '0));
  assert_load_wins_R2: assert property (@(posedge clk) disable iff (rst)
    we |=> (q == $past(wdata)));
  assert_idle_hold_R13: assert property (@(posedge clk) disable iff (rst)
    (!we && !upd) |=> $stable(q));
endmodule

// File: rtl/status_alu.sv
module status_alu
  import status_alu_pkg::*;
(
  input  logic           clk,
  input  logic           rst,
  input  logic           op_valid,
  input  logic [OPW-1:0] op_code,
  input  logic [DW-1:0]  op_a,
  input  logic [DW-1:0]  op_b,
  input  logic           flag_we,
  input  logic [DW-1:0]  flag_wdata,
  output logic [DW-1:0]  result,
  output logic [DW-1:0]  flags_next,
  output logic [DW-1:0]  flags_q
);
  logic [DW-1:0] as_a, as_b, as_sum, bo_r;
  logic          as_cin, as_sub, as_c, as_h, as_v, bo_c;
  logic          use_arith;
  logic [DW-1:0] cand, mask;
  logic          cur_c;

  assign cur_c = flags_q[FL_C];

  always_comb begin
    as_a = op_a;  as_b = op_b;  as_cin = 1'b0;  as_sub = 1'b0;
    use_arith = 1'b1;
    mask = M_NONE;
    case (op_code)
      OP_ADD: mask = M_ARITH;
      OP_ADC: begin as_cin = cur_c; mask = M_ARITH; end
      OP_SUB: begin as_sub = 1'b1; mask = M_ARITH; end
      OP_SBC: begin as_sub = 1'b1; as_cin = cur_c; mask = M_ARITH; end
      OP_NEG: begin as_a = '0; as_b = op_a; as_sub = 1'b1; mask = M_ARITH; end
      OP_INC: begin as_b = DW'(1); mask = M_LOGIC; end
      OP_DEC: begin as_b = DW'(1); as_sub = 1'b1; mask = M_LOGIC; end
      OP_AND, OP_OR, OP_XOR: begin use_arith = 1'b0; mask = M_LOGIC; end
      OP_COM, OP_LSL, OP_LSR, OP_ROL, OP_ROR, OP_ASR:
        begin use_arith = 1'b0; mask = M_SHIFT; end
      default: begin use_arith = 1'b0; mask = M_NONE; end
    endcase
  end

  status_alu_addsub #(.W(DW)) u_addsub (
    .a(as_a), .b(as_b), .cin(as_cin), .sub(as_sub),
    .sum(as_sum), .c_out(as_c), .h_out(as_h), .v_out(as_v)
  );

  status_alu_bitops #(.W(DW)) u_bitops (
    .op(op_code), .a(op_a), .b(op_b), .cin(cur_c),
    .r(bo_r), .c_out(bo_c)
  );

  assign result = use_arith ? as_sum : bo_r;

  always_comb begin
    cand        = flags_q;
    cand[FL_Z]  = (result == '0);
    cand[FL_N]  = result[DW-1];
    if (use_arith) begin
      cand[FL_C] = as_c;
      cand[FL_H] = as_h;
      cand[FL_V] = as_v;
    end else begin
      cand[FL_C] = bo_c;
      case (op_code)
        OP_LSL, OP_LSR, OP_ROL, OP_ROR, OP_ASR:
          cand[FL_V] = result[DW-1] ^ bo_c;
        default: cand[FL_V] = 1'b0;
      endcase
    end
    cand[FL_S]  = cand[FL_N] ^ cand[FL_V];
    flags_next  = (flags_q & ~mask) | (cand & mask);
  end

  status_alu_flagreg #(.W(DW)) u_flags (
    .clk(clk), .rst(rst), .we(flag_we), .wdata(flag_wdata),
    .upd(op_valid), .upd_data(flags_next), .q(flags_q)
  );

  assert_swap_keeps_flags_R11: assert property (@(posedge clk) disable iff (rst)
    (op_valid && !flag_we && op_code == OP_SWAP) |=> $stable(flags_q));
  assert_it_untouched_R12: assert property (@(posedge clk) disable iff (rst)
    (op_valid && !flag_we) |=> (flags_q[7:6] == $past(flags_q[7:6])));
  assert_sign_rule_R12: assert property (@(posedge clk) disable iff (rst)
    (op_valid && mask[FL_N]) |-> (flags_next[FL_S] == (flags_next[FL_N] ^ flags_next[FL_V])));
  assert_inc_keeps_carry_R7: assert property (@(posedge clk) disable iff (rst)
    (op_valid && !flag_we && (op_code == OP_INC || op_code == OP_DEC))
      |=> (flags_q[FL_C] == $past(flags_q[FL_C])));
endmodule

// File: tb/status_alu_bench.sv
module status_alu_bench;
  logic       clk = 1'b0;
  logic       rst, op_valid, flag_we;
  logic [4:0] op_code;
  logic [7:0] op_a, op_b, flag_wdata, result, flags_next, flags_q;
  int total = 0;
  int bad = 0;
  bit done = 0;

  always #2 clk = ~clk;

  status_alu u_status_alu (
    .clk(clk), .rst(rst), .op_valid(op_valid), .op_code(op_code),
    .op_a(op_a), .op_b(op_b), .flag_we(flag_we), .flag_wdata(flag_wdata),
    .result(result), .flags_next(flags_next), .flags_q(flags_q)
  );

  // {op, a, b, flags before, expected result, expected flags}
  localparam int NV = 31;
  localparam logic [44:0] VEC [NV] = '{
    {5'd0,  8'h0F, 8'h01, 8'h00, 8'h10, 8'h20},
    {5'd0,  8'h80, 8'h80, 8'h00, 8'h00, 8'h1B},
    {5'd1,  8'h7F, 8'h00, 8'h01, 8'h80, 8'h2C},
    {5'd0,  8'h7F, 8'h00, 8'h01, 8'h7F, 8'h00},
    {5'd1,  8'hFF, 8'h00, 8'h01, 8'h00, 8'h23},
    {5'd2,  8'h10, 8'h01, 8'h00, 8'h0F, 8'h20},
    {5'd2,  8'h00, 8'h01, 8'h00, 8'hFF, 8'h35},
    {5'd3,  8'h05, 8'h05, 8'h01, 8'hFF, 8'h35},
    {5'd3,  8'h80, 8'h00, 8'h01, 8'h7F, 8'h38},
    {5'd4,  8'hF0, 8'h3C, 8'h21, 8'h30, 8'h21},
    {5'd5,  8'h80, 8'h01, 8'h08, 8'h81, 8'h14},
    {5'd6,  8'hAA, 8'hAA, 8'hC1, 8'h00, 8'hC3},
    {5'd7,  8'h55, 8'h00, 8'h08, 8'hAA, 8'h15},
    {5'd7,  8'hFF, 8'h00, 8'h20, 8'h00, 8'h23},
    {5'd8,  8'h01, 8'h00, 8'h00, 8'hFF, 8'h35},
    {5'd8,  8'h80, 8'h00, 8'h00, 8'h80, 8'h0D},
    {5'd8,  8'h00, 8'h00, 8'h3F, 8'h00, 8'h02},
    {5'd9,  8'h7F, 8'h00, 8'h21, 8'h80, 8'h2D},
    {5'd9,  8'hFF, 8'h00, 8'h00, 8'h00, 8'h02},
    {5'd10, 8'h80, 8'h00, 8'h01, 8'h7F, 8'h19},
    {5'd10, 8'h01, 8'h00, 8'h00, 8'h00, 8'h02},
    {5'd11, 8'h81, 8'h00, 8'h20, 8'h02, 8'h39},
    {5'd12, 8'h01, 8'h00, 8'h00, 8'h00, 8'h1B},
    {5'd12, 8'h80, 8'h00, 8'h00, 8'h40, 8'h00},
    {5'd13, 8'h80, 8'h00, 8'h01, 8'h01, 8'h19},
    {5'd13, 8'h7F, 8'h00, 8'h00, 8'hFE, 8'h0C},
    {5'd14, 8'h02, 8'h00, 8'h01, 8'h81, 8'h0C},
    {5'd15, 8'h81, 8'h00, 8'h00, 8'hC0, 8'h15},
    {5'd15, 8'h40, 8'h00, 8'h00, 8'h20, 8'h00},
    {5'd16, 8'hA5, 8'h00, 8'h5A, 8'h5A, 8'h5A},
    {5'd20, 8'h3C, 8'h00, 8'h96, 8'h3C, 8'h96}
  };

  function automatic string req_of(input logic [4:0] op);
    if (op <= 5'd1)  return "R3";
    if (op <= 5'd3)  return "R4";
    if (op <= 5'd6)  return "R5";
    if (op <= 5'd8)  return "R6";
    if (op <= 5'd10) return "R7";
    if (op <= 5'd12) return "R8";
    if (op <= 5'd14) return "R9";
    if (op == 5'd15) return "R10";
    if (op == 5'd16) return "R11";
    return "R13";
  endfunction

  task automatic check(input string tag, input string what,
                       input logic [7:0] act, input logic [7:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s: actual=%02h expected=%02h", tag, what, act, exp);
    end
  endtask

  task automatic load_flags(input logic [7:0] v);
    @(negedge clk);
    flag_we = 1'b1; flag_wdata = v; op_valid = 1'b0;
    @(negedge clk);
    flag_we = 1'b0;
  endtask

  initial begin
    #(4 * 100000);
    total++; bad++;
    $display("FAIL watchdog: actual=hung expected=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    rst = 1'b1; op_valid = 1'b0; flag_we = 1'b0; flag_wdata = '0;
    op_code = '0; op_a = '0; op_b = '0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    check("R1", "reset flags", flags_q, 8'h00);

    for (int i = 0; i < NV; i++) begin
      logic [4:0] op;
      logic [7:0] va, vb, fin, res, fout;
      {op, va, vb, fin, res, fout} = VEC[i];
      load_flags(fin);
      op_valid = 1'b1; op_code = op; op_a = va; op_b = vb;
      #1;
      check(req_of(op), "result", result, res);
      check(req_of(op), "flags_next", flags_next, fout);
      @(negedge clk);
      op_valid = 1'b0;
      check(req_of(op), "flags_q", flags_q, fout);
      check("R12", "I/T kept", {flags_q[7:6], 6'b0}, {fin[7:6], 6'b0});
    end

    // R2: load wins over a simultaneous op
    load_flags(8'h00);
    flag_we = 1'b1; flag_wdata = 8'hA4;
    op_valid = 1'b1; op_code = 5'd0; op_a = 8'h80; op_b = 8'h80;
    @(negedge clk);
    flag_we = 1'b0; op_valid = 1'b0;
    check("R2", "load priority", flags_q, 8'hA4);

    // R13: idle cycles with live operands leave flags alone
    op_code = 5'd2; op_a = 8'h00; op_b = 8'h01;
    repeat (3) @(negedge clk);
    check("R13", "idle hold", flags_q, 8'hA4);

    // R1: reset clears a loaded register
    load_flags(8'hFF);
    check("R2", "direct load", flags_q, 8'hFF);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    check("R1", "reset after load", flags_q, 8'h00);

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule